// File: doc/BRIEF.md
# Low-Power Clock Gating Controller

This block turns the four low-power bits held in a processor status word into run/stop decisions for four clock trees. The trees are the fast oscillator clock, the CPU clock, a sub-system clock and an auxiliary clock. Setting the CPU-off bit alone halts instruction fetch and leaves every peripheral clock running. Each further bit stops one more source. All four bits set is the deepest sleep state. The intermediate combinations give the lighter sleep states.

Asynchronous wake-up lines are brought into the root clock domain by a two-flop synchronizer and presented as interrupt requests. A pending request restarts the fast and CPU clocks, so that the processor can take the interrupt. The CPU then marks the start and end of the service routine with single-cycle pulses. For the whole routine every gating term is suspended.

On return, the gating follows whatever bits the CPU has restored. If the routine left them untouched, the previous sleep state returns. If it cleared them, everything keeps running.

The policy runs on the always-running oscillator root `clk_i`. Enables for trees fed from the low-frequency source are re-synchronized into that domain. Each output clock passes through a latch-based gate cell. Build-time parameters choose:
- whether the sub-stop and low-frequency-stop bits have any effect;
- whether the sub-system clock is normally fed from the fast source;
- whether the auxiliary clock is fed from the low-frequency source.

Top module: `lpclk_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all four enable outputs are 1 and every irq_req_o bit is 0. After reset, all four gated clocks toggle.
- R2: With lp_bits_i[0] (CPU off) set, no service active and no request pending, cpu_en_o is 0 and cpu_clk_o has no edges. The fast clock keeps running.
- R3: With lp_bits_i[1] (fast stop) set, no service active and no request pending, fast_en_o is 0 and fast_clk_o stops. A sub-system clock fed from the fast source then falls back to the low-frequency source rather than stopping. It is never fed from both sources at once.
- R4: With lp_bits_i[2] (sub stop) set, no service active and SUB_GATE_EN = 1, sub_en_o is 0 and sub_clk_o stops.
- R5: With lp_bits_i[3] (low-frequency stop) set, no service active and OSC_GATE_EN = 1, the low-frequency source is stopped. An auxiliary clock fed from it stops (aux_en_o = 0). With all four bits set, all four gated clocks stop.
- R6: An auxiliary clock fed from the low-frequency source keeps running in every state that leaves lp_bits_i[3] clear.
- R7: irq_req_o[i] follows wake_i[i] through exactly two clk_i flops. It is 0 after one rising edge and 1 after the second.
- R8: While any irq_req_o bit is 1, fast_en_o and cpu_en_o are 1 from the next cycle on, whatever the bits. The sub and auxiliary gating stay as the bits request.
- R9: From the cycle after an irq_take_i pulse until an irq_ret_i pulse, all four bits are ignored and all four enables are 1. If both pulses arrive in the same cycle, the take wins.
- R10: After irq_ret_i, gating follows lp_bits_i again. Unchanged bits restore the earlier sleep state. Cleared bits leave all clocks running.
- R11: With SUB_GATE_EN = 0 the sub-system clock keeps running in every state that sets lp_bits_i[2]. With OSC_GATE_EN = 0 as well, the low-frequency fallback keeps the sub-system clock running even with all four bits set.
- R12: With AUX_FROM_LF = 0 the auxiliary clock follows the fast clock. It runs exactly when fast_en_o is 1.
- R13: The enable outputs are registered. A change on lp_bits_i is visible on them one clk_i rising edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running fast oscillator root; clocks the policy logic |
| lf_clk_i | input | 1 | Free-running low-frequency oscillator root |
| rst_i | input | 1 | Synchronous active-high power-up clear |
| lp_bits_i | input | 4 | [0] CPU off, [1] fast stop, [2] sub stop, [3] low-frequency stop |
| wake_i | input | N_WAKE | Asynchronous wake-up lines |
| irq_take_i | input | 1 | One-cycle pulse: interrupt accepted, service begins |
| irq_ret_i | input | 1 | One-cycle pulse: return from service |
| irq_req_o | output | N_WAKE | Synchronized wake-up lines, used as interrupt requests |
| fast_en_o | output | 1 | Fast clock enable |
| cpu_en_o | output | 1 | CPU clock enable |
| sub_en_o | output | 1 | Sub-system clock enable (either source) |
| aux_en_o | output | 1 | Auxiliary clock enable |
| fast_clk_o | output | 1 | Gated fast clock |
| cpu_clk_o | output | 1 | Gated CPU clock |
| sub_clk_o | output | 1 | Gated sub-system clock |
| aux_clk_o | output | 1 | Gated auxiliary clock |

## Verification
The checker tracks the service window from the take and return pulses. It therefore assumes the CPU issues a return only after a take, and never both in one cycle. The bench pulses each for a single clk_i cycle, with the return many cycles after the take.

The bench changes lp_bits_i, wake_i and the pulses only on falling edges of clk_i, so every rule is sampled on a settled value. It measures gated clocks only after a settling gap long enough for the low-frequency enable crossing, which takes about three slow cycles.

// File: rtl/lpclk_pkg.sv
package lpclk_pkg;

  // Low-power control word as seen on lp_bits_i.
  typedef struct packed {
    logic lf_stop;    // [3]
    logic sub_stop;   // [2]
    logic fast_stop;  // [1]
    logic cpu_off;    // [0]
  } lp_bits_t;

  // Per-tree run decisions, one bit per gate cell.
  typedef struct packed {
    logic aux_lf;
    logic aux_fast;
    logic sub_lf;
    logic sub_fast;
    logic cpu;
    logic fast;
  } clk_en_t;

  // Map the control word plus service/wake state onto the gate enables.
  function automatic clk_en_t decide(
    input lp_bits_t b,
    input logic     svc,
    input logic     wk,
    input bit       sub_gate_en,
    input bit       osc_gate_en,
    input bit       sub_from_fast,
    input bit       aux_from_lf
  );
    clk_en_t e;
    logic cpu_off_e, fast_stop_e, sub_stop_e, lf_stop_e, lf_run;
    cpu_off_e   = b.cpu_off   & ~svc & ~wk;
    fast_stop_e = b.fast_stop & ~svc & ~wk;
    sub_stop_e  = b.sub_stop  & ~svc & logic'(sub_gate_en);
    lf_stop_e   = b.lf_stop   & ~svc & logic'(osc_gate_en);
    lf_run      = ~lf_stop_e;
    e.fast      = ~fast_stop_e;
    e.cpu       = ~cpu_off_e;
    e.sub_fast  = logic'(sub_from_fast) & e.fast & ~sub_stop_e;
    e.sub_lf    = ~sub_stop_e & lf_run & ~(logic'(sub_from_fast) & e.fast);
    e.aux_lf    = logic'(aux_from_lf) & lf_run;
    e.aux_fast  = ~logic'(aux_from_lf) & e.fast;
    return e;
  endfunction

endpackage

// File: rtl/lpclk_sync.sv
module lpclk_sync #(
  parameter int unsigned          WIDTH   = 1,
  parameter int unsigned          STAGES  = 2,
  parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] st;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int s = 0; s < STAGES; s++) st[s] <= RST_VAL;
    end else begin
      st[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q_o = st[STAGES-1];

endmodule

// File: rtl/lpclk_icg.sv
module lpclk_icg (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);

  logic en_l;

  // Transparent while the clock is low: a high phase is never cut short.
  always_latch begin
    if (!clk_i) en_l = en_i;
  end

  assign gclk_o = clk_i & en_l;

endmodule

// File: rtl/lpclk_policy.sv
module lpclk_policy #(
  parameter bit SUB_GATE_EN   = 1'b1,
  parameter bit OSC_GATE_EN   = 1'b1,
  parameter bit SUB_FROM_FAST = 1'b1,
  parameter bit AUX_FROM_LF   = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  lpclk_pkg::lp_bits_t  bits_i,
  input  logic                 wake_pend_i,
  input  logic                 take_i,
  input  logic                 ret_i,
  output lpclk_pkg::clk_en_t   en_o
);
  import lpclk_pkg::*;

  localparam clk_en_t EN_RST =
    decide('0, 1'b0, 1'b0, SUB_GATE_EN, OSC_GATE_EN, SUB_FROM_FAST, AUX_FROM_LF);

  logic    svc_q;
  clk_en_t en_q;

  // Service window: take has priority over return.
  always_ff @(posedge clk_i) begin
    if (rst_i)       svc_q <= 1'b0;
    else if (take_i) svc_q <= 1'b1;
    else if (ret_i)  svc_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) en_q <= EN_RST;
    else       en_q <= decide(bits_i, svc_q, wake_pend_i,
                              SUB_GATE_EN, OSC_GATE_EN, SUB_FROM_FAST, AUX_FROM_LF);
  end

  assign en_o = en_q;

endmodule

// File: rtl/lpclk_ctrl.sv
module lpclk_ctrl #(
  parameter int unsigned N_WAKE        = 2,
  parameter int unsigned LF_STAGES     = 2,
  parameter bit          SUB_GATE_EN   = 1'b1,
  parameter bit          OSC_GATE_EN   = 1'b1,
  parameter bit          SUB_FROM_FAST = 1'b1,
  parameter bit          AUX_FROM_LF   = 1'b1
) (
  input  logic              clk_i,
  input  logic              lf_clk_i,
  input  logic              rst_i,
  input  logic [3:0]        lp_bits_i,
  input  logic [N_WAKE-1:0] wake_i,
  input  logic              irq_take_i,
  input  logic              irq_ret_i,
  output logic [N_WAKE-1:0] irq_req_o,
  output logic              fast_en_o,
  output logic              cpu_en_o,
  output logic              sub_en_o,
  output logic              aux_en_o,
  output logic              fast_clk_o,
  output logic              cpu_clk_o,
  output logic              sub_clk_o,
  output logic              aux_clk_o
);
  import lpclk_pkg::*;

  localparam int unsigned WAKE_STAGES = 2;
  localparam int unsigned LF_W        = 2;
  localparam clk_en_t EN_RST =
    decide('0, 1'b0, 1'b0, SUB_GATE_EN, OSC_GATE_EN, SUB_FROM_FAST, AUX_FROM_LF);
  localparam logic [LF_W-1:0] LF_RST = {EN_RST.aux_lf, EN_RST.sub_lf};

  logic [N_WAKE-1:0] req;
  clk_en_t           en;
  logic              en_sub_fast, en_sub_lf;
  logic [LF_W-1:0]   lf_en_s;
  logic              g_sub_fast, g_sub_lf;

  // Wake-up lines into the root domain.
  lpclk_sync #(.WIDTH(N_WAKE), .STAGES(WAKE_STAGES), .RST_VAL('0)) u_wake_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (wake_i),
    .q_o   (req)
  );
  assign irq_req_o = req;

  lpclk_policy #(
    .SUB_GATE_EN   (SUB_GATE_EN),
    .OSC_GATE_EN   (OSC_GATE_EN),
    .SUB_FROM_FAST (SUB_FROM_FAST),
    .AUX_FROM_LF   (AUX_FROM_LF)
  ) u_policy (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .bits_i      (lp_bits_t'(lp_bits_i)),
    .wake_pend_i (|req),
    .take_i      (irq_take_i),
    .ret_i       (irq_ret_i),
    .en_o        (en)
  );

  assign en_sub_fast = en.sub_fast;
  assign en_sub_lf   = en.sub_lf;
  assign fast_en_o   = en.fast;
  assign cpu_en_o    = en.cpu;
  assign sub_en_o    = en.sub_fast | en.sub_lf;
  assign aux_en_o    = en.aux_fast | en.aux_lf;

  // Enables for gates on the slow root cross into its domain.
  lpclk_sync #(.WIDTH(LF_W), .STAGES(LF_STAGES), .RST_VAL(LF_RST)) u_lf_sync (
    .clk_i (lf_clk_i),
    .rst_i (rst_i),
    .d_i   ({en.aux_lf, en.sub_lf}),
    .q_o   (lf_en_s)
  );

  lpclk_icg u_gate_fast (.clk_i(clk_i),    .en_i(en.fast),     .gclk_o(fast_clk_o));
  lpclk_icg u_gate_cpu  (.clk_i(clk_i),    .en_i(en.cpu),      .gclk_o(cpu_clk_o));
  lpclk_icg u_gate_subf (.clk_i(clk_i),    .en_i(en.sub_fast), .gclk_o(g_sub_fast));
  lpclk_icg u_gate_subl (.clk_i(lf_clk_i), .en_i(lf_en_s[0]),  .gclk_o(g_sub_lf));

  assign sub_clk_o = g_sub_fast | g_sub_lf;

  generate
    if (AUX_FROM_LF) begin : g_aux_lf
      lpclk_icg u_gate_aux (.clk_i(lf_clk_i), .en_i(lf_en_s[1]), .gclk_o(aux_clk_o));
    end else begin : g_aux_fast
      lpclk_icg u_gate_aux (.clk_i(clk_i), .en_i(en.aux_fast), .gclk_o(aux_clk_o));
    end
  endgenerate

endmodule

// File: rtl/lpclk_ctrl_chk.sv
module lpclk_ctrl_chk #(
  parameter int unsigned N_WAKE      = 2,
  parameter bit          SUB_GATE_EN = 1'b1,
  parameter bit          OSC_GATE_EN = 1'b1,
  parameter bit          AUX_FROM_LF = 1'b1
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [3:0]        lp_bits_i,
  input logic [N_WAKE-1:0] wake_i,
  input logic              irq_take_i,
  input logic              irq_ret_i,
  input logic [N_WAKE-1:0] irq_req_o,
  input logic              fast_en_o,
  input logic              cpu_en_o,
  input logic              sub_en_o,
  input logic              aux_en_o,
  input logic              en_sub_fast,
  input logic              en_sub_lf
);

  logic svc_m;
  always_ff @(posedge clk_i) begin
    if (rst_i)           svc_m <= 1'b0;
    else if (irq_take_i) svc_m <= 1'b1;
    else if (irq_ret_i)  svc_m <= 1'b0;
  end

  assert_reset_run_R1: assert property (@(posedge clk_i)
    $fell(rst_i) |-> (fast_en_o && cpu_en_o && sub_en_o && aux_en_o && irq_req_o == '0));

  assert_cpu_stop_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (lp_bits_i[0] && !svc_m && irq_req_o == '0) |=> !cpu_en_o);

  assert_fast_stop_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (lp_bits_i[1] && !svc_m && irq_req_o == '0) |=> !fast_en_o);

  assert_sub_one_src_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({en_sub_fast, en_sub_lf}));

  assert_sub_stop_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (SUB_GATE_EN && lp_bits_i[2] && !svc_m) |=> !sub_en_o);

  assert_aux_stop_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (OSC_GATE_EN && AUX_FROM_LF && lp_bits_i[3] && !svc_m) |=> !aux_en_o);

  generate
    for (genvar i = 0; i < N_WAKE; i++) begin : g_wk
      assert_wake_sync_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_req_o[i]) |-> $past(wake_i[i], 2));
    end
  endgenerate

  assert_wake_run_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_req_o != '0) |=> (fast_en_o && cpu_en_o));

  assert_service_run_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    svc_m |=> (fast_en_o && cpu_en_o && sub_en_o && aux_en_o));

endmodule

bind lpclk_ctrl lpclk_ctrl_chk #(
  .N_WAKE      (N_WAKE),
  .SUB_GATE_EN (SUB_GATE_EN),
  .OSC_GATE_EN (OSC_GATE_EN),
  .AUX_FROM_LF (AUX_FROM_LF)
) chk_i (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .lp_bits_i   (lp_bits_i),
  .wake_i      (wake_i),
  .irq_take_i  (irq_take_i),
  .irq_ret_i   (irq_ret_i),
  .irq_req_o   (irq_req_o),
  .fast_en_o   (fast_en_o),
  .cpu_en_o    (cpu_en_o),
  .sub_en_o    (sub_en_o),
  .aux_en_o    (aux_en_o),
  .en_sub_fast (en_sub_fast),
  .en_sub_lf   (en_sub_lf)
);

// File: tb/lpclk_ctrl_tb_top.sv
module lpclk_ctrl_tb_top;

  localparam int NW  = 2;
  localparam int WIN = 100;

  logic clk = 1'b0, lf_clk = 1'b0, rst = 1'b1;
  logic [3:0]    bits = 4'b0;
  logic [NW-1:0] wake = '0;
  logic take = 1'b0, ret = 1'b0;

  always #4  clk    = ~clk;     // 125 MHz
  always #28 lf_clk = ~lf_clk;

  logic [NW-1:0] req, req2;
  logic fe, ce, se, ae, fc, cc, sc, ac;
  logic fe2, ce2, se2, ae2, fc2, cc2, sc2, ac2;

  lpclk_ctrl #(.N_WAKE(NW)) dut_i (
    .clk_i(clk), .lf_clk_i(lf_clk), .rst_i(rst), .lp_bits_i(bits), .wake_i(wake),
    .irq_take_i(take), .irq_ret_i(ret), .irq_req_o(req),
    .fast_en_o(fe), .cpu_en_o(ce), .sub_en_o(se), .aux_en_o(ae),
    .fast_clk_o(fc), .cpu_clk_o(cc), .sub_clk_o(sc), .aux_clk_o(ac));

  // Variant: sub-stop and lf-stop disabled, auxiliary fed from the fast source.
  lpclk_ctrl #(.N_WAKE(NW), .SUB_GATE_EN(1'b0), .OSC_GATE_EN(1'b0), .AUX_FROM_LF(1'b0)) dut2_i (
    .clk_i(clk), .lf_clk_i(lf_clk), .rst_i(rst), .lp_bits_i(bits), .wake_i(wake),
    .irq_take_i(take), .irq_ret_i(ret), .irq_req_o(req2),
    .fast_en_o(fe2), .cpu_en_o(ce2), .sub_en_o(se2), .aux_en_o(ae2),
    .fast_clk_o(fc2), .cpu_clk_o(cc2), .sub_clk_o(sc2), .aux_clk_o(ac2));

  int n_fc = 0, n_cc = 0, n_sc = 0, n_ac = 0, n_sc2 = 0, n_ac2 = 0;
  always @(posedge fc)  n_fc++;
  always @(posedge cc)  n_cc++;
  always @(posedge sc)  n_sc++;
  always @(posedge ac)  n_ac++;
  always @(posedge sc2) n_sc2++;
  always @(posedge ac2) n_ac2++;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req_s, input string what, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req_s, what, act, lo, hi);
    end
  endtask

  typedef struct { int f, c, s, a, s2, a2; } cnt_t;

  task automatic measure(output cnt_t m);
    cnt_t b;
    b.f = n_fc; b.c = n_cc; b.s = n_sc; b.a = n_ac; b.s2 = n_sc2; b.a2 = n_ac2;
    tick(WIN);
    m.f = n_fc - b.f; m.c = n_cc - b.c; m.s = n_sc - b.s;
    m.a = n_ac - b.a; m.s2 = n_sc2 - b.s2; m.a2 = n_ac2 - b.a2;
  endtask

  // Low-frequency edges in a WIN-cycle window: about 14.
  localparam int LF_LO = 8, LF_HI = 20;

  task automatic set_mode(input logic [3:0] m);
    bits = m;
    tick(40);
  endtask

  task automatic t_reset;
    cnt_t m;
    chk("R1", "enables in reset", {fe, ce, se, ae}, 15, 15);
    rst = 1'b0;
    tick(1);
    chk("R1", "enables after reset", {fe, ce, se, ae}, 15, 15);
    chk("R1", "irq_req after reset", req, 0, 0);
    tick(20);
    measure(m);
    chk("R1", "fast edges", m.f, WIN, WIN);
    chk("R1", "cpu edges", m.c, WIN, WIN);
    chk("R1", "sub edges", m.s, WIN, WIN);
    chk("R1", "aux edges", m.a, LF_LO, LF_HI);
  endtask

  task automatic t_cpu_off;
    cnt_t m;
    bits = 4'b0001;
    chk("R13", "cpu_en before edge", ce, 1, 1);
    tick(1);
    chk("R13", "cpu_en one edge later", ce, 0, 0);
    tick(40);
    measure(m);
    chk("R2", "cpu edges", m.c, 0, 0);
    chk("R2", "fast edges", m.f, WIN, WIN);
    chk("R6", "aux edges", m.a, LF_LO, LF_HI);
  endtask

  task automatic t_fast_stop;
    cnt_t m;
    set_mode(4'b0011);
    measure(m);
    chk("R3", "fast_en", fe, 0, 0);
    chk("R3", "fast edges", m.f, 0, 0);
    chk("R3", "sub fallback edges", m.s, LF_LO, LF_HI);
    chk("R3", "sub_en", se, 1, 1);
    chk("R6", "aux edges", m.a, LF_LO, LF_HI);
    chk("R12", "variant aux edges", m.a2, 0, 0);
  endtask

  task automatic t_sub_stop;
    cnt_t m;
    set_mode(4'b0101);
    measure(m);
    chk("R4", "sub edges", m.s, 0, 0);
    chk("R4", "sub_en", se, 0, 0);
    chk("R6", "aux edges", m.a, LF_LO, LF_HI);
    chk("R11", "variant sub edges", m.s2, WIN, WIN);
    chk("R12", "variant aux edges", m.a2, WIN, WIN);
    set_mode(4'b0111);
    measure(m);
    chk("R6", "aux edges fast+sub stop", m.a, LF_LO, LF_HI);
    chk("R4", "sub edges fast+sub stop", m.s, 0, 0);
    chk("R11", "variant sub edges fast+sub stop", m.s2, LF_LO, LF_HI);
  endtask

  task automatic t_deep;
    cnt_t m;
    set_mode(4'b1111);
    measure(m);
    chk("R5", "fast edges", m.f, 0, 0);
    chk("R5", "cpu edges", m.c, 0, 0);
    chk("R5", "sub edges", m.s, 0, 0);
    chk("R5", "aux edges", m.a, 0, 0);
    chk("R5", "aux_en", ae, 0, 0);
    chk("R11", "variant sub edges", m.s2, LF_LO, LF_HI);
  endtask

  task automatic t_wake_service(input int line, input bit clear_bits);
    cnt_t m;
    wake[line] = 1'b1;
    tick(1);
    chk("R7", "irq_req after one edge", req[line], 0, 0);
    tick(1);
    chk("R7", "irq_req after two edges", req[line], 1, 1);
    tick(1);
    chk("R8", "fast/cpu/sub/aux en while pending", {fe, ce, se, ae}, 12, 12);
    take = 1'b1;
    tick(1);
    take = 1'b0;
    wake[line] = 1'b0;
    tick(40);
    measure(m);
    chk("R9", "fast edges in service", m.f, WIN, WIN);
    chk("R9", "cpu edges in service", m.c, WIN, WIN);
    chk("R9", "sub edges in service", m.s, WIN, WIN);
    chk("R9", "aux edges in service", m.a, LF_LO, LF_HI);
    if (clear_bits) bits = 4'b0000;
    ret = 1'b1;
    tick(1);
    ret = 1'b0;
    tick(40);
    measure(m);
    if (clear_bits) begin
      chk("R10", "cpu edges after cleared return", m.c, WIN, WIN);
      chk("R10", "sub edges after cleared return", m.s, WIN, WIN);
      chk("R10", "aux edges after cleared return", m.a, LF_LO, LF_HI);
    end else begin
      chk("R10", "cpu edges after return", m.c, 0, 0);
      chk("R10", "fast edges after return", m.f, 0, 0);
      chk("R10", "sub edges after return", m.s, 0, 0);
      chk("R10", "aux edges after return", m.a, 0, 0);
    end
  endtask

  initial begin
    tick(30);
    t_reset();
    t_cpu_off();
    t_fast_stop();
    t_sub_stop();
    t_deep();
    t_wake_service(0, 1'b0);
    t_wake_service(1, 1'b1);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule